// File: doc/BRIEF.md
# Handshake-Terminated Asynchronous Bus Master

This block is the master side of an external asynchronous parallel bus that carries one word per transaction to a slave whose response time varies, for example a programmable-logic device. Address and data share one set of pins. Each transaction starts with an address phase, which is marked by an address-latch strobe. A data phase follows, framed by chip select and by either a read or a write strobe. The slave ends the data phase with an acknowledge line, which may change at any time relative to the bus clock.

An internal requester hands over one access at a time through a valid/ready handshake. Configuration inputs are sampled when an access is accepted. They set, separately for reads and writes, how many cycles chip select waits after the access starts and the minimum number of data-phase cycles. They also set the data-phase cycle from which the acknowledge may be honoured, whether the acknowledge is used at all, and how many polling cycles pass before the access is given up. A completion pulse returns read data and an error flag.

Top module: `dtack_bus_master`

## Requirements
- R1: `req_ready` is high only while no access is open. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the cycle in which `rsp_valid` is high.
- R2: Number the cycles after the accepting edge 1, 2, and so on. In cycle 1 only, `bus_ale` is high, `bus_ad_oe` is high and `bus_ad_o` carries the address. `bus_ale` is low in every other cycle.
- R3: Let D be the chip-select delay field for the access direction. `bus_cs_n` first goes low in cycle 1 when D=0, and in cycle 1+D otherwise. It then stays low through the last data-phase cycle.
- R4: The data phase starts in cycle S = 1+max(1,D). With the acknowledge disabled, it lasts exactly W cycles, where W is the wait field for the access direction. A W of 0 is treated as 1.
- R5: With the acknowledge enabled, the acknowledge is honoured only in data-phase cycles k (counted from 0) with k >= max(W-1, P), where P is the poll-start field. The data phase ends with the first such cycle in which the synchronised acknowledge is high.
- R6: `bus_dtack` passes through a two-stage synchroniser. A level that first becomes high during cycle a becomes usable in cycle a+2.
- R7: For a write, throughout the data phase `bus_we_n` is low, `bus_oe_n` is high, `bus_ad_oe` is high and `bus_ad_o` carries the write data.
- R8: For a read, throughout the data phase `bus_oe_n` is low, `bus_we_n` is high and `bus_ad_oe` is low. `bus_ad_i` is captured on the edge that closes the last data-phase cycle and appears on `rsp_rdata` together with `rsp_valid`.
- R9: `rsp_valid` is high for exactly one cycle, the cycle right after the last data-phase cycle. In that cycle `bus_cs_n`, `bus_oe_n` and `bus_we_n` are all high.
- R10: With the acknowledge enabled, if none is seen in T eligible cycles (a T of 0 is treated as 1), the access ends after the T-th eligible cycle and `rsp_err` is 1 with `rsp_valid`. Otherwise `rsp_err` is 0.
- R11: With the acknowledge disabled, a high `bus_dtack` has no effect on the access length.
- R12: Reads use only the read delay and read wait fields. Writes use only the write delay and write wait fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADW | Access address |
| req_wdata | input | ADW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | ADW | Captured read data |
| rsp_err | output | 1 | Acknowledge timeout on the completed access |
| cfg_dtack_en | input | 1 | Use the acknowledge to end accesses |
| cfg_rd_csdly | input | CDW | Chip-select delay for reads |
| cfg_wr_csdly | input | CDW | Chip-select delay for writes |
| cfg_rd_wait | input | WW | Minimum data-phase cycles for reads |
| cfg_wr_wait | input | WW | Minimum data-phase cycles for writes |
| cfg_poll_start | input | WW | First data-phase cycle at which the acknowledge counts |
| cfg_timeout | input | TW | Eligible polling cycles before abort |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address-latch strobe, active high |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ad_o | output | ADW | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | ADW | Multiplexed data in |
| bus_dtack | input | 1 | Slave acknowledge, asynchronous, active high |

## Verification
The bench counts cycles from the accepting edge. It predicts from R3 to R6 and R10 in which cycle chip select first falls, how many strobe cycles follow, and the cycle in which `rsp_valid` rises. For this it adds the two synchroniser stages to the cycle in which it raised the acknowledge, and it clamps zero fields to one. Every output is sampled on the falling edge of the cycle it belongs to. The bench compares the cycle index it records against the prediction, so an error of even one cycle in the delay, the minimum length, the poll start or the timeout shows up as a mismatch.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_CSDLY = 2'd2,
    ST_DATA  = 2'd3
  } dbm_state_e;

endpackage

// File: rtl/dbm_sync.sv
module dbm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbm_counter.sv
module dbm_counter #(
  parameter int W   = 8,
  parameter bit SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] q_q, q_d;
  logic         en;

  generate
    if (SAT) begin : g_sat
      always_comb begin
        q_d = q_q;
        if (clr_i)                    q_d = '0;
        else if (inc_i && q_q != MAXV) q_d = q_q + W'(1);
      end
    end else begin : g_wrap
      always_comb begin
        q_d = q_q;
        if (clr_i)      q_d = '0;
        else if (inc_i) q_d = q_q + W'(1);
      end
    end
  endgenerate

  assign en = clr_i | inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/dbm_sequencer.sv
module dbm_sequencer
  import dbm_pkg::*;
#(
  parameter int CDW = 3,
  parameter int WW  = 6,
  parameter int TW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [CDW-1:0] cs_dly_i,
  input  logic [WW-1:0]  wait_i,
  input  logic [WW-1:0]  poll_i,
  input  logic           dtack_en_i,
  input  logic [TW-1:0]  tmo_i,
  input  logic           dtack_i,
  output dbm_state_e     state_o,
  output logic           end_o,
  output logic           err_o
);

  localparam int PHW = ((WW > CDW) ? WW : CDW) + 1;

  dbm_state_e     st_q, st_d;
  logic [PHW-1:0] phase;
  logic [TW-1:0]  tcnt;
  logic           ph_clr, ph_inc, tm_clr, tm_inc;
  logic [PHW-1:0] wc_x, wlast_x, poll_x, emin_x, cs_x;
  logic [TW-1:0]  tc;
  logic           eligible;

  // Clamp reserved zero settings to one
  always_comb begin
    wc_x    = (wait_i == '0) ? PHW'(1) : PHW'(wait_i);
    wlast_x = wc_x - PHW'(1);
    poll_x  = PHW'(poll_i);
    emin_x  = (wlast_x > poll_x) ? wlast_x : poll_x;
    cs_x    = PHW'(cs_dly_i);
    tc      = (tmo_i == '0) ? TW'(1) : tmo_i;
  end

  assign eligible = (phase >= emin_x);

  dbm_counter #(.W(PHW), .SAT(1'b1)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ph_clr),
    .inc_i (ph_inc),
    .q_o   (phase)
  );

  dbm_counter #(.W(TW), .SAT(1'b0)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tm_clr),
    .inc_i (tm_inc),
    .q_o   (tcnt)
  );

  always_comb begin
    st_d   = st_q;
    ph_clr = 1'b0;
    ph_inc = 1'b0;
    tm_clr = 1'b0;
    tm_inc = 1'b0;
    end_o  = 1'b0;
    err_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ADDR;
          ph_clr = 1'b1;
          tm_clr = 1'b1;
        end
      end
      ST_ADDR: begin
        ph_clr = 1'b1;
        st_d   = (cs_x > PHW'(1)) ? ST_CSDLY : ST_DATA;
      end
      ST_CSDLY: begin
        if (phase == cs_x - PHW'(2)) begin
          ph_clr = 1'b1;
          st_d   = ST_DATA;
        end else begin
          ph_inc = 1'b1;
        end
      end
      ST_DATA: begin
        ph_inc = 1'b1;
        if (!dtack_en_i) begin
          if (phase >= wlast_x) end_o = 1'b1;
        end else if (eligible) begin
          if (dtack_i) begin
            end_o = 1'b1;
          end else if (tcnt == tc - TW'(1)) begin
            end_o = 1'b1;
            err_o = 1'b1;
          end else begin
            tm_inc = 1'b1;
          end
        end
        if (end_o) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R9: an access can only close from the data phase
  p_end_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> (st_q == ST_DATA));

  // R5: the acknowledge never closes an access before the poll start
  p_poll_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && dtack_en_i) |-> (phase >= poll_x));

  // R10: the polling counter never runs past the programmed limit
  p_timeout_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && dtack_en_i) |-> (tcnt < tc));

  // R10: an error close only happens without an acknowledge
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (dtack_en_i && !dtack_i));

endmodule

// File: rtl/dtack_bus_master.sv
module dtack_bus_master
  import dbm_pkg::*;
#(
  parameter int ADW = 16,
  parameter int CDW = 3,
  parameter int WW  = 6,
  parameter int TW  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [ADW-1:0] req_addr,
  input  logic [ADW-1:0] req_wdata,
  output logic           rsp_valid,
  output logic [ADW-1:0] rsp_rdata,
  output logic           rsp_err,
  input  logic           cfg_dtack_en,
  input  logic [CDW-1:0] cfg_rd_csdly,
  input  logic [CDW-1:0] cfg_wr_csdly,
  input  logic [WW-1:0]  cfg_rd_wait,
  input  logic [WW-1:0]  cfg_wr_wait,
  input  logic [WW-1:0]  cfg_poll_start,
  input  logic [TW-1:0]  cfg_timeout,
  output logic           bus_cs_n,
  output logic           bus_ale,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [ADW-1:0] bus_ad_o,
  output logic           bus_ad_oe,
  input  logic [ADW-1:0] bus_ad_i,
  input  logic           bus_dtack
);

  dbm_state_e     state;
  logic           accept, acc_end, acc_err, dtack_s;
  logic           wr_q, den_q;
  logic [ADW-1:0] addr_q, wdata_q, rdata_q;
  logic [CDW-1:0] cs_q;
  logic [WW-1:0]  wait_q, poll_q;
  logic [TW-1:0]  tmo_q;
  logic           vld_q, err_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  // Request and configuration capture, one set per access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      den_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cs_q    <= '0;
      wait_q  <= '0;
      poll_q  <= '0;
      tmo_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      den_q   <= cfg_dtack_en;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      cs_q    <= req_write ? cfg_wr_csdly : cfg_rd_csdly;
      wait_q  <= req_write ? cfg_wr_wait  : cfg_rd_wait;
      poll_q  <= cfg_poll_start;
      tmo_q   <= cfg_timeout;
    end
  end

  dbm_sync #(.STAGES(SYNC_STAGES)) u_dtack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bus_dtack),
    .sync_o  (dtack_s)
  );

  dbm_sequencer #(.CDW(CDW), .WW(WW), .TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .cs_dly_i   (cs_q),
    .wait_i     (wait_q),
    .poll_i     (poll_q),
    .dtack_en_i (den_q),
    .tmo_i      (tmo_q),
    .dtack_i    (dtack_s),
    .state_o    (state),
    .end_o      (acc_end),
    .err_o      (acc_err)
  );

  // Pin decode from the sequencer state
  always_comb begin
    bus_ale   = (state == ST_ADDR);
    bus_cs_n  = !((state == ST_DATA) || ((state == ST_ADDR) && (cs_q == '0)));
    bus_oe_n  = !((state == ST_DATA) && !wr_q);
    bus_we_n  = !((state == ST_DATA) &&  wr_q);
    bus_ad_oe = (state == ST_ADDR) ||
                (wr_q && ((state == ST_CSDLY) || (state == ST_DATA)));
    bus_ad_o  = (state == ST_ADDR) ? addr_q : wdata_q;
  end

  // Completion register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= acc_end;
      err_q <= acc_end & acc_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (acc_end && !wr_q)   rdata_q <= bus_ad_i;
  end

  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  // R2: the address strobe lasts one cycle
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  // R3: a strobe is only driven inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  // R8: read and write strobes never overlap, and a read leaves the lines free
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_we_n && !bus_ad_oe));

  // R1: an idle block drives no bus cycle
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_oe_n && bus_we_n && !bus_ale));

  // R9: the completion flag is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: chip select is released when the completion is reported
  p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_cs_n && bus_oe_n && bus_we_n));

endmodule

// File: tb/dtack_bus_master_test.sv
module dtack_bus_master_test;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        cfg_dtack_en;
  logic [2:0]  cfg_rd_csdly, cfg_wr_csdly;
  logic [5:0]  cfg_rd_wait, cfg_wr_wait, cfg_poll_start;
  logic [7:0]  cfg_timeout;
  logic        bus_cs_n, bus_ale, bus_oe_n, bus_we_n, bus_ad_oe, bus_dtack;
  logic [15:0] bus_ad_o, bus_ad_i;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  dtack_bus_master uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_dtack_en(cfg_dtack_en), .cfg_rd_csdly(cfg_rd_csdly), .cfg_wr_csdly(cfg_wr_csdly),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .cfg_poll_start(cfg_poll_start), .cfg_timeout(cfg_timeout),
    .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_dtack(bus_dtack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Drives one access and checks every observable timing point.
  // da = cycle in which the acknowledge is raised (0 = never).
  task automatic run_access(input bit wr, input int cs, input int w, input int p,
                            input bit den, input int t, input int da,
                            input logic [15:0] addr, input logic [15:0] data);
    int cyc, s, wc, tc, e, kd, last, cs_first, cs_cnt, st_cnt, ale_cnt;
    int wrong, dbad, busy, addr_ok, exp_err, exp_cs;
    cs_first = 0; cs_cnt = 0; st_cnt = 0; ale_cnt = 0; wrong = 0; dbad = 0;
    busy = 0; addr_ok = 0;
    wc = (w == 0) ? 1 : w;
    tc = (t == 0) ? 1 : t;
    s  = 1 + imax(1, cs);
    exp_err = 0;
    if (!den) last = s + wc - 1;
    else begin
      e  = imax(wc - 1, p);
      kd = imax(0, da + 2 - s);
      if (da == 0 || kd > e + tc - 1) begin
        last = s + e + tc - 1;
        exp_err = 1;
      end else last = s + imax(e, kd);
    end
    exp_cs = (cs == 0) ? 1 : s;

    // R12: the other direction's fields hold different values
    if (wr) begin
      cfg_wr_csdly = 3'(cs); cfg_wr_wait = 6'(w);
      cfg_rd_csdly = 3'(cs + 3); cfg_rd_wait = 6'(w + 5);
    end else begin
      cfg_rd_csdly = 3'(cs); cfg_rd_wait = 6'(w);
      cfg_wr_csdly = 3'(cs + 3); cfg_wr_wait = 6'(w + 5);
    end
    cfg_poll_start = 6'(p);
    cfg_dtack_en   = den;
    cfg_timeout    = 8'(t);
    bus_ad_i       = data;

    @(negedge clk);
    chk("R1 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 700) begin
      if (bus_ale) ale_cnt++;
      if (cyc == 1 && bus_ale && bus_ad_oe && bus_ad_o == addr) addr_ok = 1;
      if (!bus_cs_n) begin
        cs_cnt++;
        if (cs_first == 0) cs_first = cyc;
      end
      if (!bus_oe_n || !bus_we_n) begin
        st_cnt++;
        if (wr && !(bus_ad_oe && bus_ad_o == data)) dbad++;
        if (!wr && bus_ad_oe) dbad++;
      end
      if (wr ? !bus_oe_n : !bus_we_n) wrong++;
      if (req_ready) busy++;
      if (cyc == da) bus_dtack = 1'b1;
      @(negedge clk);
      cyc++;
    end

    chk("R9 completion cycle", cyc, last + 1);
    chk("R2 address phase", addr_ok, 1);
    chk("R2 ale count", ale_cnt, 1);
    chk("R3 chip select first cycle", cs_first, exp_cs);
    chk("R3 chip select length", cs_cnt, last - exp_cs + 1);
    chk(den ? "R5 strobe length" : "R4 strobe length", st_cnt, last - s + 1);
    chk(wr ? "R7 strobe type" : "R8 strobe type", wrong, 0);
    chk(wr ? "R7 write data drive" : "R8 read lines free", dbad, 0);
    chk("R1 ready low while busy", busy, 0);
    chk("R9 released at completion", int'(bus_cs_n & bus_oe_n & bus_we_n), 1);
    chk("R10 error flag", int'(rsp_err), exp_err);
    if (!wr && !exp_err) chk("R8 read data", int'(rsp_rdata), int'(data));
    bus_dtack = 1'b0;
    @(negedge clk);
    chk("R9 single pulse", int'(rsp_valid), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R9 reset cs", int'(bus_cs_n), 1);
    chk("R9 reset strobes", int'(bus_oe_n & bus_we_n), 1);
    chk("R2 reset ale", int'(bus_ale), 0);
    chk("R9 reset valid", int'(rsp_valid), 0);
  endtask

  task automatic test_fixed_length();   // R4, R12
    run_access(1'b0, 1, 3, 0, 1'b0, 4, 0, 16'h1234, 16'hA5C3);
    run_access(1'b1, 2, 5, 0, 1'b0, 4, 0, 16'h4321, 16'h5A3C);
    run_access(1'b1, 0, 2, 0, 1'b0, 4, 0, 16'h00F0, 16'h0F0F);
  endtask

  task automatic test_zero_wait();      // R4 clamp
    run_access(1'b0, 1, 0, 0, 1'b0, 4, 0, 16'h0001, 16'hBEEF);
  endtask

  task automatic test_dtack_disabled(); // R11
    run_access(1'b0, 1, 4, 0, 1'b0, 4, 1, 16'h0002, 16'h1111);
  endtask

  task automatic test_dtack_late();     // R5, R6
    run_access(1'b0, 1, 2, 0, 1'b1, 30, 10, 16'h0003, 16'h2222);
    run_access(1'b1, 3, 1, 0, 1'b1, 30, 7,  16'h0004, 16'h3333);
  endtask

  task automatic test_dtack_early();    // R5: minimum length still holds
    run_access(1'b0, 1, 4, 0, 1'b1, 10, 1, 16'h0005, 16'h4444);
  endtask

  task automatic test_poll_start();     // R5: poll start beyond wait
    run_access(1'b1, 1, 1, 5, 1'b1, 10, 1, 16'h0006, 16'h5555);
  endtask

  task automatic test_timeout();        // R10
    run_access(1'b0, 1, 2, 0, 1'b1, 4, 0, 16'h0007, 16'h6666);
    run_access(1'b0, 2, 1, 3, 1'b1, 0, 0, 16'h0008, 16'h7777);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_dtack_en = 1'b0; cfg_rd_csdly = '0; cfg_wr_csdly = '0; cfg_rd_wait = 6'd1;
    cfg_wr_wait = 6'd1; cfg_poll_start = '0; cfg_timeout = 8'd1;
    bus_ad_i = '0; bus_dtack = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_fixed_length();
    test_zero_wait();
    test_dtack_disabled();
    test_dtack_late();
    test_dtack_early();
    test_poll_start();
    test_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule